// File: doc/BRIEF.md
# Serial Link Signal-Validity Detector

This block judges whether a recovered 8b/10b serial bit stream is carrying real Fibre Channel traffic. It is fed one recovered bit per clock together with a qualifying strobe. Two kinds of fault are looked for in the stream. The first is a run of identical bits that is longer than the line code allows. The second is a stretch of time in which the comma pattern of the K28.5 character never shows up. Time is cut into fixed windows counted in qualified bit times, and each window is scored as errored or clean.

The window scores drive an active-low fail output. A mode input picks the policy. In the direct policy the output follows the score of the latest window. In the hysteresis policy it takes four errored windows in a row to assert the output and four clean windows in a row to release it. The hysteresis policy is meant for driving a loop-isolation multiplexer directly. The direct policy suits a controller that applies its own filtering.

Top module: `link_validity_det`

## Requirements
- R1: A qualified bit that extends a run of identical values (ones or zeros) beyond MAX_RUN (default 5) marks the current window errored; a run of exactly MAX_RUN does not.
- R2: The 7-bit patterns 0000101 and 1111010, earliest-received bit written first, each count as a comma, so K28.5 is found in either running disparity.
- R3: A window in which no comma completes is errored even when it has no run error.
- R4: A window is exactly 2^INTERVAL_LOG2 qualified bits long. The fail output takes its new value on the clock edge that samples the window's last bit.
- R5: Clocks with `bit_vld` low are ignored: they do not advance the window count, the run length or the pattern window, whatever `bit_in` holds.
- R6: With `multi_mode` low, `fail_n` goes low after an errored window and high after a clean window, and changes at no other time.
- R7: With `multi_mode` high, `fail_n` goes low only after HYST_LEN (default 4) consecutive errored windows.
- R8: With `multi_mode` high, `fail_n` goes high only after HYST_LEN consecutive clean windows; a single errored window restarts the count.
- R9: Synchronous reset drives `fail_n` low and clears all counters. The pattern window cannot report a comma until 7 qualified bits have arrived since reset.
- R10: A change on `multi_mode` clears both consecutive-window counters and leaves `fail_n` unchanged.
- R11: A run or comma that straddles a window boundary is credited to the window in which it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Recovered serial bit |
| multi_mode | input | 1 | 0 = direct policy, 1 = hysteresis policy |
| fail_n | output | 1 | Low when the stream is judged invalid |

## Verification
The bench goes after runs of exactly five, which a design with an off-by-one limit would flag as errors. It checks runs of six that straddle a window edge, which a design clearing the run counter at the edge would miss. It also sends a comma whose first bits fall in the previous window, which a design clearing the pattern window would miss. Unqualified clocks carry inverted bits inside runs, so a design that samples them would break runs and shift window edges. Right after reset the bench sends a pattern whose first three bits complete a comma only against a zero-filled window; a design without a fill count would release the fail output there. In hysteresis mode the bench sends streaks of three and of four, interrupted streaks, and a mode toggle in mid-streak. A design that did not restart its counts on an interrupting window or a mode change would then switch the output early.

// File: rtl/sd_pkg.sv
package sd_pkg;

  localparam int COMMA_W = 7;
  localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b0000101;
  localparam logic [COMMA_W-1:0] COMMA_POS = 7'b1111010;

  // window is oldest bit in the MSB
  function automatic logic is_comma(input logic [COMMA_W-1:0] w);
    return (w == COMMA_NEG) || (w == COMMA_POS);
  endfunction

  function automatic logic window_bad(input logic run_seen, input logic comma_seen);
    return run_seen || !comma_seen;
  endfunction

endpackage

// File: rtl/sd_run_mon.sv
module sd_run_mon #(
  parameter int MAX_RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic din,
  output logic run_err
);
  localparam int RUN_W = $clog2(MAX_RUN + 2);
  localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(MAX_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MAX_RUN);

  logic             last_q;
  logic [RUN_W-1:0] len_q, len_nx;

  always_comb begin
    if (len_q != '0 && din == last_q)
      len_nx = (len_q == RUN_CAP) ? len_q : len_q + 1'b1;
    else
      len_nx = RUN_W'(1);
  end

  assign run_err = vld && (len_nx > RUN_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      len_q  <= '0;
    end else if (vld) begin
      last_q <= din;
      len_q  <= len_nx;
    end
  end
endmodule

// File: rtl/sd_comma_scan.sv
module sd_comma_scan (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic din,
  output logic comma_hit
);
  import sd_pkg::*;
  localparam int FILL_W = $clog2(COMMA_W + 1);
  localparam logic [FILL_W-1:0] FILL_MIN = FILL_W'(COMMA_W - 1);

  logic [COMMA_W-1:0] win_q, win_nx;
  logic [FILL_W-1:0]  fill_q;

  assign win_nx    = {win_q[COMMA_W-2:0], din};
  assign comma_hit = vld && (fill_q >= FILL_MIN) && is_comma(win_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (vld) begin
      win_q <= win_nx;
      if (fill_q < FILL_MIN) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sd_interval.sv
module sd_interval #(
  parameter int LOG2 = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic            run_err,
  input  logic            comma_hit,
  output logic            iv_done,
  output logic            iv_err,
  output logic [LOG2-1:0] iv_cnt
);
  import sd_pkg::*;

  logic [LOG2-1:0] cnt_q;
  logic            run_seen_q, comma_seen_q;

  assign iv_cnt  = cnt_q;
  assign iv_done = vld && (&cnt_q);
  assign iv_err  = window_bad(run_seen_q || run_err, comma_seen_q || comma_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      run_seen_q   <= 1'b0;
      comma_seen_q <= 1'b0;
    end else if (vld) begin
      cnt_q <= cnt_q + 1'b1;
      if (iv_done) begin
        run_seen_q   <= 1'b0;
        comma_seen_q <= 1'b0;
      end else begin
        run_seen_q   <= run_seen_q || run_err;
        comma_seen_q <= comma_seen_q || comma_hit;
      end
    end
  end
endmodule

// File: rtl/sd_fail_policy.sv
module sd_fail_policy #(
  parameter int HYST = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       multi_mode,
  input  logic                       iv_done,
  input  logic                       iv_err,
  output logic                       fail_n,
  output logic                       mode_chg,
  output logic [$clog2(HYST+1)-1:0]  err_cnt,
  output logic [$clog2(HYST+1)-1:0]  ok_cnt
);
  localparam int CW = $clog2(HYST + 1);
  localparam logic [CW-1:0] CAP = CW'(HYST);

  logic          mode_q, fail_q, fail_nx;
  logic [CW-1:0] err_q, ok_q, err_base, ok_base, err_nx, ok_nx;

  assign mode_chg = (multi_mode != mode_q);

  always_comb begin
    err_base = mode_chg ? '0 : err_q;
    ok_base  = mode_chg ? '0 : ok_q;
    err_nx   = err_base;
    ok_nx    = ok_base;
    fail_nx  = fail_q;
    if (iv_done) begin
      if (iv_err) begin
        ok_nx  = '0;
        err_nx = (err_base == CAP) ? CAP : err_base + 1'b1;
      end else begin
        err_nx = '0;
        ok_nx  = (ok_base == CAP) ? CAP : ok_base + 1'b1;
      end
      if (!multi_mode)                    fail_nx = iv_err;
      else if (iv_err && err_nx == CAP)   fail_nx = 1'b1;
      else if (!iv_err && ok_nx == CAP)   fail_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= multi_mode;
      fail_q <= 1'b1;
      err_q  <= '0;
      ok_q   <= '0;
    end else begin
      mode_q <= multi_mode;
      fail_q <= fail_nx;
      err_q  <= err_nx;
      ok_q   <= ok_nx;
    end
  end

  assign fail_n  = ~fail_q;
  assign err_cnt = err_q;
  assign ok_cnt  = ok_q;
endmodule

// File: rtl/link_validity_det.sv
module link_validity_det #(
  parameter int INTERVAL_LOG2 = 15,
  parameter int MAX_RUN       = 5,
  parameter int HYST_LEN      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic multi_mode,
  output logic fail_n
);
  localparam int CW = $clog2(HYST_LEN + 1);

  logic                     run_err, comma_hit, iv_done, iv_err, mode_chg;
  logic [INTERVAL_LOG2-1:0] iv_cnt;
  logic [CW-1:0]            err_cnt, ok_cnt;

  sd_run_mon #(.MAX_RUN(MAX_RUN)) u_run (
    .clk(clk), .rst(rst), .vld(bit_vld), .din(bit_in), .run_err(run_err)
  );

  sd_comma_scan u_comma (
    .clk(clk), .rst(rst), .vld(bit_vld), .din(bit_in), .comma_hit(comma_hit)
  );

  sd_interval #(.LOG2(INTERVAL_LOG2)) u_iv (
    .clk(clk), .rst(rst), .vld(bit_vld), .run_err(run_err),
    .comma_hit(comma_hit), .iv_done(iv_done), .iv_err(iv_err), .iv_cnt(iv_cnt)
  );

  sd_fail_policy #(.HYST(HYST_LEN)) u_pol (
    .clk(clk), .rst(rst), .multi_mode(multi_mode), .iv_done(iv_done),
    .iv_err(iv_err), .fail_n(fail_n), .mode_chg(mode_chg),
    .err_cnt(err_cnt), .ok_cnt(ok_cnt)
  );
endmodule

// File: rtl/sd_checks.sv
module sd_checks #(
  parameter int LOG2 = 15,
  parameter int HYST = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bit_vld,
  input logic                      multi_mode,
  input logic                      fail_n,
  input logic                      iv_done,
  input logic                      iv_err,
  input logic                      mode_chg,
  input logic [LOG2-1:0]           iv_cnt,
  input logic [$clog2(HYST+1)-1:0] err_cnt,
  input logic [$clog2(HYST+1)-1:0] ok_cnt
);
  localparam int CW = $clog2(HYST + 1);
  localparam logic [CW-1:0] LAST = CW'(HYST - 1);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R9: leaving reset, the output reports a failed link
  always @(posedge clk)
    if (rst_d === 1'b1 && rst === 1'b0)
      p_reset_fail_r9: assert (fail_n == 1'b0);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(iv_cnt));

  p_done_needs_bit_r4: assert property (@(posedge clk) disable iff (rst)
    iv_done |-> bit_vld);

  p_fail_only_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    !iv_done |=> $stable(fail_n));

  p_single_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (iv_done && !multi_mode) |=> (fail_n != $past(iv_err)));

  p_multi_hold_err_r7: assert property (@(posedge clk) disable iff (rst)
    (iv_done && multi_mode && iv_err && !mode_chg && err_cnt < LAST) |=> $stable(fail_n));

  p_multi_hold_ok_r8: assert property (@(posedge clk) disable iff (rst)
    (iv_done && multi_mode && !iv_err && !mode_chg && ok_cnt < LAST) |=> $stable(fail_n));

  p_mode_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_chg && !iv_done) |=> (err_cnt == '0 && ok_cnt == '0));
endmodule

bind link_validity_det sd_checks #(.LOG2(INTERVAL_LOG2), .HYST(HYST_LEN)) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .multi_mode(multi_mode),
  .fail_n(fail_n), .iv_done(iv_done), .iv_err(iv_err), .mode_chg(mode_chg),
  .iv_cnt(iv_cnt), .err_cnt(err_cnt), .ok_cnt(ok_cnt)
);

// File: tb/link_validity_det_tb.sv
module link_validity_det_tb;
  localparam int IL = 6;
  localparam int NB = 1 << IL;
  localparam int H  = 4;

  logic clk = 1'b0;
  logic rst, bit_vld, bit_in, multi_mode;
  logic fail_n;

  always #5 clk = ~clk;

  link_validity_det #(.INTERVAL_LOG2(IL)) u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .multi_mode(multi_mode), .fail_n(fail_n)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit    exp_q[$];
  string req_q[$];
  bit    ivb[NB];
  bit    gaps = 0;
  int    nbits = 0;

  // independent policy model
  bit m_fail = 1;
  bit m_mode = 0;
  int m_err = 0;
  int m_ok  = 0;

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: fail_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic void model_window(input bit errd);
    if (!m_mode) m_fail = errd;
    else if (errd) begin
      m_ok = 0; m_err++;
      if (m_err >= H) m_fail = 1;
    end else begin
      m_err = 0; m_ok++;
      if (m_ok >= H) m_fail = 0;
    end
  endfunction

  // K28.5 words, first transmitted bit is the MSB
  function automatic void fill_k(input bit pos);
    logic [9:0] w;
    w = pos ? 10'b1100000101 : 10'b0011111010;
    for (int i = 0; i < NB; i++) ivb[i] = w[9 - (i % 10)];
  endfunction

  function automatic void fill_alt(input bit first);
    for (int i = 0; i < NB; i++) ivb[i] = first ^ bit'(i % 2);
  endfunction

  task automatic send(input bit errd, input string req);
    model_window(errd);
    exp_q.push_back(!m_fail);
    req_q.push_back(req);
    for (int i = 0; i < NB; i++) begin
      if (gaps && (i % 5 == 2)) begin
        bit_vld = 1'b0; bit_in = ~ivb[i];
        @(negedge clk);
      end
      bit_vld = 1'b1; bit_in = ivb[i];
      @(negedge clk);
    end
    bit_vld = 1'b0;
  endtask

  task automatic set_mode(input bit v);
    multi_mode = v; m_mode = v; m_err = 0; m_ok = 0;
    @(negedge clk);
  endtask

  // monitor: one expected item per completed window
  always @(posedge clk) begin
    #1;
    if (rst === 1'b0 && bit_vld === 1'b1) begin
      nbits++;
      if (nbits % NB == 0) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4: window ended with nothing expected, fail_n=%b expected none", fail_n);
        end else begin
          bit e; string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(fail_n === e, r, fail_n, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, done=0 expected 1");
      report();
      $finish;
    end
  end

  initial begin
    logic held;
    rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0; multi_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(fail_n === 1'b0, "R9 reset state", fail_n, 1'b0);

    // R9: 1,0,1 would match 0000101 only against a zero-filled window
    fill_alt(1); send(1, "R9 no comma from reset fill");
    fill_k(0);   send(0, "R2 negative-disparity comma, R6 release");
    fill_k(1);   send(0, "R2 positive comma, R1 run of exactly 5");
    fill_alt(1); send(1, "R3 window without comma");
    fill_k(0);   send(0, "R6 clean releases");
    fill_k(0); for (int i = 30; i < 36; i++) ivb[i] = 1'b1; ivb[36] = 1'b0;
    send(1, "R1 run of six ones");
    fill_k(0);   send(0, "R6 clean after run");
    fill_k(1); for (int i = 30; i < 36; i++) ivb[i] = 1'b0; ivb[36] = 1'b1;
    send(1, "R1 run of six zeros");

    gaps = 1;
    fill_k(0);   send(0, "R5 gaps ignored on clean stream");
    fill_k(0); for (int i = 30; i < 36; i++) ivb[i] = 1'b1; ivb[36] = 1'b0;
    send(1, "R5 gap inside run does not break it");
    gaps = 0;

    // R11: run straddling the boundary
    fill_k(0); ivb[60] = 1'b0; ivb[61] = 1'b1; ivb[62] = 1'b1; ivb[63] = 1'b1;
    send(0, "R11 first half of straddling run");
    fill_k(0); ivb[0] = 1'b1; ivb[1] = 1'b1; ivb[2] = 1'b1; ivb[3] = 1'b0;
    send(1, "R11 run completes in later window");
    fill_k(0); send(0, "R6 clean");
    // R11: comma straddling the boundary
    fill_alt(1); for (int i = 60; i < 64; i++) ivb[i] = 1'b0;
    send(1, "R11 comma start does not count early");
    fill_alt(1); send(0, "R11 comma completes in later window");

    // hysteresis policy, fail_n currently high
    set_mode(1);
    check(fail_n === 1'b1, "R10 mode change keeps level", fail_n, 1'b1);
    fill_alt(1); send(1, "R7 errored 1 of 4");
    fill_alt(1); send(1, "R7 errored 2 of 4");
    fill_alt(1); send(1, "R7 errored 3 of 4");
    fill_alt(1); send(1, "R7 errored 4 of 4 asserts");
    fill_k(0);   send(0, "R8 clean 1 of 4");
    fill_k(1);   send(0, "R8 clean 2 of 4");
    fill_alt(1); send(1, "R8 errored window restarts count");
    fill_k(0);   send(0, "R8 clean 1 again");
    fill_k(0);   send(0, "R8 clean 2 again");
    fill_k(0);   send(0, "R8 clean 3 again");
    fill_k(0);   send(0, "R8 clean 4 releases");
    fill_alt(1); send(1, "R7 errored 1");
    fill_alt(1); send(1, "R7 errored 2");
    fill_k(0);   send(0, "R7 clean breaks streak");
    fill_alt(1); send(1, "R7 errored 1 again");
    fill_alt(1); send(1, "R7 errored 2 again");
    fill_alt(1); send(1, "R7 errored 3 again");
    fill_alt(1); send(1, "R7 errored 4 asserts");

    // R10: toggle mode in mid-streak
    fill_k(0); send(0, "R10 clean 1 before toggle");
    fill_k(0); send(0, "R10 clean 2 before toggle");
    held = fail_n;
    set_mode(0);
    check(fail_n === held, "R10 switch to direct keeps level", fail_n, held);
    set_mode(1);
    check(fail_n === held, "R10 switch back keeps level", fail_n, held);
    fill_k(0); send(0, "R10 clean 1 after toggle");
    fill_k(0); send(0, "R10 clean 2 after toggle holds");
    fill_k(0); send(0, "R10 clean 3 after toggle");
    fill_k(0); send(0, "R10 clean 4 after toggle releases");

    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R4 every window reported", 1'(exp_q.size() != 0), 1'b0);
    finished = 1;
    report();
    $finish;
  end
endmodule